// File: doc/BRIEF.md
# Blanking-Interval Ancillary Packet Formatter

This block takes the data bytes sliced from one vertical-blanking video line and emits them as a single ancillary packet on a byte stream with valid/ready flow control. Each packet opens with a fixed three-byte preamble. A data identifier byte follows, then a secondary identifier byte that packs the line's status flags and the top two bits of its 10-bit line number. After that come a word-count byte, the payload itself, an 8-bit checksum, and enough fill bytes to bring the packet to a whole number of 4-byte words.

The word count precedes the payload, so the formatter first captures the whole line into a small internal line buffer. During capture it accepts bytes with `inReady` high. Once the closing byte is in, it drops `inReady` and plays the packet out, stalling whenever the downstream consumer holds `outReady` low. The status flags and line-number bits are sampled on the closing byte of the line. A line that fills the buffer is closed at that byte.

Top module: `vbi_anc_formatter`

## Requirements
- R1: Every packet begins with the bytes 00h, FFh, FFh, followed by the data identifier given by the parameter `DATA_ID`.
- R2: The fifth byte (secondary identifier) holds the line number bits [9:8] in bits 1:0, the second match flag in bit 2, the first match flag in bit 3, the error flag in bit 4, and zero in bits 7:5. All of these are sampled when the line's closing byte is accepted.
- R3: The sixth byte is the payload length in 4-byte words, rounded up (ceil(n/4) for n payload bytes).
- R4: The payload bytes follow the count byte, in the order they were accepted and with their values unchanged.
- R5: The byte after the payload is the modulo-256 sum of every byte from the data identifier through the last payload byte. The preamble is not included in the sum.
- R6: Fill bytes of value 80h follow the checksum, so that the byte count from the data identifier through the last fill byte is a multiple of 4. When it already is, there are no fill bytes.
- R7: `outLast` is high with the final byte of the packet, and `outValid` is low in the cycle after that byte is taken.
- R8: While `outReady` is low, `outValid`, `outData` and `outLast` hold their values. No byte is lost or repeated.
- R9: After reset `inReady` is high and `outValid` is low. `inReady` stays low for as long as a packet is being emitted.
- R10: When a line reaches `MAX_BYTES` bytes without an end marker, it is closed at that byte. The next accepted byte starts a new line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inData | input | 8 | Sliced payload byte |
| inValid | input | 1 | inData holds a byte |
| inLast | input | 1 | The current byte closes the line |
| inReady | output | 1 | The formatter can accept a byte |
| lineHi | input | 2 | Bits [9:8] of the line number, sampled on the closing byte |
| match1 | input | 1 | First match flag, sampled on the closing byte |
| match2 | input | 1 | Second match flag, sampled on the closing byte |
| lineErr | input | 1 | Error-detected flag, sampled on the closing byte |
| outData | output | 8 | Packet byte |
| outValid | output | 1 | outData holds a packet byte |
| outLast | output | 1 | Final byte of the packet |
| outReady | input | 1 | Consumer takes the byte this cycle |

## Verification
The assertions assume that a packet, once begun, is only ever ended by the byte flagged with `outLast`. They also assume that the first byte after any idle period is a preamble byte, which holds only if nothing but a captured line can start emission. The bench respects the input handshake: it presents a byte only while `inReady` is high and keeps it steady until the clock edge that takes it. It holds the flag and line-number inputs constant across each line, so the values sampled on the closing byte are the ones it expects. On the output side it drives `outReady` in several stall patterns. Every payload length from 1 to the buffer depth is covered, and one line is overrun on purpose to exercise R10.

// File: rtl/vbi_anc_pkg.sv
package vbi_anc_pkg;

  localparam logic [7:0] PRE_ZERO  = 8'h00;
  localparam logic [7:0] PRE_ONES  = 8'hFF;
  localparam logic [7:0] FILL_BYTE = 8'h80;

  typedef enum logic [3:0] {
    PH_PRE0,
    PH_PRE1,
    PH_PRE2,
    PH_DID,
    PH_SDID,
    PH_DC,
    PH_PAY,
    PH_CS,
    PH_FILL
  } phase_e;

  typedef struct packed {
    logic   capWr;    // store inData into the line buffer
    logic   capFirst; // stored byte is the first of its line
    logic   capClose; // stored byte closes the line: latch flags
    phase_e phase;    // which packet field is on the output
  } anc_ctrl_t;

endpackage

// File: rtl/vbi_anc_ctrl.sv
module vbi_anc_ctrl
  import vbi_anc_pkg::*;
#(
  parameter int MAX_BYTES = 32,
  parameter int PTR_W     = $clog2(MAX_BYTES),
  parameter int LEN_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inLast,
  output logic             inReady,
  input  logic             outReady,
  output logic             outValid,
  output logic             outLast,
  output anc_ctrl_t        ctrl,
  output logic [PTR_W-1:0] wrIdx,
  output logic [PTR_W-1:0] rdIdx,
  output logic [LEN_W-1:0] lineLen
);

  logic             sending;
  phase_e           phase;
  logic [PTR_W-1:0] idx;
  logic [PTR_W-1:0] wrPtr;
  logic [1:0]       fillCnt;
  logic             accept;
  logic             closeNow;
  logic             step;
  logic             payEnd;
  logic             fillEnd;

  assign inReady  = !sending;
  assign accept   = inValid && inReady;
  assign closeNow = accept && (inLast || (wrPtr == PTR_W'(MAX_BYTES - 1)));
  assign step     = sending && outReady;
  assign fillCnt  = 2'(3'd4 - {1'b0, lineLen[1:0]});
  assign payEnd   = (idx == PTR_W'(lineLen - LEN_W'(1)));
  assign fillEnd  = (idx == PTR_W'(fillCnt - 2'd1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sending <= 1'b0;
      phase   <= PH_PRE0;
      idx     <= '0;
      wrPtr   <= '0;
      lineLen <= '0;
    end else begin
      if (closeNow) begin
        sending <= 1'b1;
        phase   <= PH_PRE0;
        idx     <= '0;
        wrPtr   <= '0;
        lineLen <= LEN_W'(wrPtr) + LEN_W'(1);
      end else if (accept) begin
        wrPtr <= wrPtr + PTR_W'(1);
      end
      if (step) begin
        unique case (phase)
          PH_PRE0: phase <= PH_PRE1;
          PH_PRE1: phase <= PH_PRE2;
          PH_PRE2: phase <= PH_DID;
          PH_DID:  phase <= PH_SDID;
          PH_SDID: phase <= PH_DC;
          PH_DC: begin
            phase <= PH_PAY;
            idx   <= '0;
          end
          PH_PAY: begin
            if (payEnd) phase <= PH_CS;
            else        idx   <= idx + PTR_W'(1);
          end
          PH_CS: begin
            idx <= '0;
            if (fillCnt == 2'd0) begin
              sending <= 1'b0;
              phase   <= PH_PRE0;
            end else begin
              phase <= PH_FILL;
            end
          end
          PH_FILL: begin
            if (fillEnd) begin
              sending <= 1'b0;
              phase   <= PH_PRE0;
              idx     <= '0;
            end else begin
              idx <= idx + PTR_W'(1);
            end
          end
          default: phase <= PH_PRE0;
        endcase
      end
    end
  end

  assign outValid = sending;
  assign outLast  = sending && (((phase == PH_CS) && (fillCnt == 2'd0)) ||
                                ((phase == PH_FILL) && fillEnd));

  assign ctrl.capWr    = accept;
  assign ctrl.capFirst = (wrPtr == '0);
  assign ctrl.capClose = closeNow;
  assign ctrl.phase    = phase;
  assign wrIdx         = wrPtr;
  assign rdIdx         = idx;

endmodule

// File: rtl/vbi_anc_dpath.sv
module vbi_anc_dpath
  import vbi_anc_pkg::*;
#(
  parameter int         MAX_BYTES = 32,
  parameter logic [7:0] DATA_ID   = 8'h5A,
  parameter int         PTR_W     = $clog2(MAX_BYTES),
  parameter int         LEN_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  anc_ctrl_t        ctrl,
  input  logic [PTR_W-1:0] wrIdx,
  input  logic [PTR_W-1:0] rdIdx,
  input  logic [LEN_W-1:0] lineLen,
  input  logic [7:0]       inData,
  input  logic [1:0]       lineHi,
  input  logic             match1,
  input  logic             match2,
  input  logic             lineErr,
  output logic [7:0]       outData
);

  logic [7:0] lineBuf [MAX_BYTES];
  logic [7:0] paySum;
  logic [7:0] sdidReg;
  logic [7:0] wordCnt;
  logic [7:0] checkSum;

  always_ff @(posedge clk) begin
    if (ctrl.capWr) lineBuf[wrIdx] <= inData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      paySum  <= '0;
      sdidReg <= '0;
    end else begin
      if (ctrl.capWr) paySum <= ctrl.capFirst ? inData : paySum + inData;
      if (ctrl.capClose) sdidReg <= {3'b000, lineErr, match1, match2, lineHi};
    end
  end

  assign wordCnt  = 8'(({1'b0, lineLen} + (LEN_W + 1)'(3)) >> 2);
  assign checkSum = DATA_ID + sdidReg + wordCnt + paySum;

  always_comb begin
    unique case (ctrl.phase)
      PH_PRE0: outData = PRE_ZERO;
      PH_PRE1: outData = PRE_ONES;
      PH_PRE2: outData = PRE_ONES;
      PH_DID:  outData = DATA_ID;
      PH_SDID: outData = sdidReg;
      PH_DC:   outData = wordCnt;
      PH_PAY:  outData = lineBuf[rdIdx];
      PH_CS:   outData = checkSum;
      default: outData = FILL_BYTE;
    endcase
  end

endmodule

// File: rtl/vbi_anc_formatter.sv
module vbi_anc_formatter
  import vbi_anc_pkg::*;
#(
  parameter int         MAX_BYTES = 32,
  parameter logic [7:0] DATA_ID   = 8'h5A
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] inData,
  input  logic       inValid,
  input  logic       inLast,
  output logic       inReady,
  input  logic [1:0] lineHi,
  input  logic       match1,
  input  logic       match2,
  input  logic       lineErr,
  output logic [7:0] outData,
  output logic       outValid,
  output logic       outLast,
  input  logic       outReady
);

  localparam int PTR_W = $clog2(MAX_BYTES);
  localparam int LEN_W = $clog2(MAX_BYTES + 1);

  anc_ctrl_t        ctrl;
  logic [PTR_W-1:0] wrIdx;
  logic [PTR_W-1:0] rdIdx;
  logic [LEN_W-1:0] lineLen;

  vbi_anc_ctrl #(
    .MAX_BYTES(MAX_BYTES), .PTR_W(PTR_W), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inLast(inLast), .inReady(inReady),
    .outReady(outReady), .outValid(outValid), .outLast(outLast),
    .ctrl(ctrl), .wrIdx(wrIdx), .rdIdx(rdIdx), .lineLen(lineLen)
  );

  vbi_anc_dpath #(
    .MAX_BYTES(MAX_BYTES), .DATA_ID(DATA_ID), .PTR_W(PTR_W), .LEN_W(LEN_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN),
    .ctrl(ctrl), .wrIdx(wrIdx), .rdIdx(rdIdx), .lineLen(lineLen),
    .inData(inData), .lineHi(lineHi), .match1(match1), .match2(match2),
    .lineErr(lineErr), .outData(outData)
  );

endmodule

// File: rtl/vbi_anc_checker.sv
module vbi_anc_checker (
  input logic       clk,
  input logic       rstN,
  input logic       outValid,
  input logic       outReady,
  input logic       outLast,
  input logic [7:0] outData
);

  logic [15:0] pktCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pktCnt <= '0;
    else if (outValid && outReady) pktCnt <= outLast ? 16'd0 : pktCnt + 16'd1;
  end

  AST_PREAMBLE_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> (outData == 8'h00)); // R1

  AST_WORD_MULTIPLE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outLast) |-> (pktCnt[1:0] == 2'd2)); // R6

  AST_LAST_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outLast) |=> !outValid); // R7

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outLast))); // R8

  AST_NO_EARLY_END: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !(outReady && outLast)) |=> outValid); // R8

endmodule

bind vbi_anc_formatter vbi_anc_checker u_chk (
  .clk(clk), .rstN(rstN), .outValid(outValid), .outReady(outReady),
  .outLast(outLast), .outData(outData)
);

// File: tb/vbi_anc_formatter_tb.sv
module vbi_anc_formatter_tb;

  localparam int         MAXB = 8;
  localparam logic [7:0] DID  = 8'hA7;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] inData = '0;
  logic       inValid = 1'b0;
  logic       inLast = 1'b0;
  logic       inReady;
  logic [1:0] lineHi = '0;
  logic       match1 = 1'b0;
  logic       match2 = 1'b0;
  logic       lineErr = 1'b0;
  logic [7:0] outData;
  logic       outValid;
  logic       outLast;
  logic       outReady = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [7:0] got [64];
  int gotLen;

  always #4 clk = ~clk;

  vbi_anc_formatter #(.MAX_BYTES(MAXB), .DATA_ID(DID)) u_dut (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid),
    .inLast(inLast), .inReady(inReady), .lineHi(lineHi), .match1(match1),
    .match2(match2), .lineErr(lineErr), .outData(outData),
    .outValid(outValid), .outLast(outLast), .outReady(outReady)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] byteVal(input int seed, input int i);
    return 8'((seed * 29 + i * 53 + 7) & 255);
  endfunction

  task automatic sendLine(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      while (!inReady) @(negedge clk);
      inData  = byteVal(seed, i);
      inValid = 1'b1;
      inLast  = (i == n - 1);
      @(negedge clk);
    end
    inValid = 1'b0;
    inLast  = 1'b0;
  endtask

  task automatic recvPacket(input int mode);
    bit done = 0;
    bit heldPend = 0;
    bit firstSeen = 0;
    logic [7:0] heldData = '0;
    int cyc = 0;
    gotLen = 0;
    while (!done) begin
      case (mode)
        0: outReady = 1'b1;
        1: outReady = (cyc % 3) != 0;
        default: outReady = (cyc % 5) >= 2;
      endcase
      if (heldPend) begin
        chk(outValid && (outData == heldData), "R8", "held byte", outData, heldData);
        heldPend = 0;
      end
      if (outValid && !firstSeen) begin
        chk(!inReady, "R9", "inReady during emission", inReady, 0);
        firstSeen = 1;
      end
      if (outValid && !outReady) begin
        heldData = outData;
        heldPend = 1;
      end
      if (outValid && outReady) begin
        got[gotLen] = outData;
        gotLen++;
        if (outLast) done = 1;
      end
      cyc++;
      @(negedge clk);
    end
    outReady = 1'b0;
    chk(!outValid, "R7", "outValid after last", outValid, 0);
    chk(inReady, "R9", "inReady after packet", inReady, 1);
  endtask

  task automatic checkPacket(input int n, input int seed, input int off,
                             input logic [7:0] sdid);
    logic [7:0] exp [64];
    int words = (n + 3) / 4;
    int expLen = 3 + 4 * words + 4;
    int fill = expLen - (n + 7);
    logic [7:0] sum = '0;
    int bad = 0;
    exp[0] = 8'h00; exp[1] = 8'hFF; exp[2] = 8'hFF;
    exp[3] = DID; exp[4] = sdid; exp[5] = 8'(words);
    for (int j = 0; j < n; j++) exp[6 + j] = byteVal(seed, off + j);
    for (int j = 3; j < 6 + n; j++) sum = sum + exp[j];
    exp[6 + n] = sum;
    for (int j = 0; j < fill; j++) exp[7 + n + j] = 8'h80;
    chk(gotLen == expLen, "R6", "packet length", gotLen, expLen);
    if (gotLen != expLen) return;
    chk(got[0] == 8'h00 && got[1] == 8'hFF && got[2] == 8'hFF, "R1", "preamble",
        {got[0], got[1], got[2]}, 24'h00FFFF);
    chk(got[3] == DID, "R1", "data id", got[3], DID);
    chk(got[4] == sdid, "R2", "secondary id", got[4], sdid);
    chk(got[5] == exp[5], "R3", "word count", got[5], exp[5]);
    for (int j = 0; j < n; j++) if (got[6 + j] != exp[6 + j]) bad++;
    chk(bad == 0, "R4", "payload mismatches", bad, 0);
    chk(got[6 + n] == exp[6 + n], "R5", "checksum", got[6 + n], exp[6 + n]);
    bad = 0;
    for (int j = 0; j < fill; j++) if (got[7 + n + j] != 8'h80) bad++;
    chk(bad == 0, "R6", "fill bytes wrong", bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(inReady == 1'b1, "R9", "reset inReady", inReady, 1);
    chk(outValid == 1'b0, "R9", "reset outValid", outValid, 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int n = 1; n <= MAXB; n++) begin
      for (int pat = 0; pat < 3; pat++) begin
        int line = (n * 97 + pat * 301) % 1024;
        int fl = (n * 3 + pat) & 7;
        logic [7:0] sdid;
        lineHi  = 2'(line >> 8);
        lineErr = fl[2];
        match1  = fl[1];
        match2  = fl[0];
        sdid = {3'b000, fl[2], fl[1], fl[0], 2'(line >> 8)};
        sendLine(n, n * 7 + pat);
        recvPacket(pat);
        checkPacket(n, n * 7 + pat, 0, sdid);
      end
    end

    // R10: overrun one line past the buffer depth
    lineHi = 2'd3; lineErr = 1'b1; match1 = 1'b0; match2 = 1'b1;
    fork
      sendLine(MAXB + 1, 55);
      begin
        recvPacket(1);
        checkPacket(MAXB, 55, 0, 8'b0001_0111);
        chk(gotLen == 3 + MAXB + 4 + ((4 - MAXB % 4) % 4), "R10", "truncated length",
            gotLen, 3 + MAXB + 4 + ((4 - MAXB % 4) % 4));
        recvPacket(0);
        checkPacket(1, 55, MAXB, 8'b0001_0111);
        chk(got[6] == byteVal(55, MAXB), "R10", "carried-over byte", got[6], byteVal(55, MAXB));
      end
    join

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule